// File: doc/BRIEF.md
# Block-Reseeded Pseudo-Random Pattern Source

This generator emits a long test stimulus as a chain of pseudo-random runs of equal length. Each run comes from an external-feedback (Type I) shift register whose state is reloaded at every run boundary. The first run begins from an initial seed captured when the test is launched. Each later run begins from the next entry of a small on-block seed table, taken in ascending address order. The seeds are meant to be deterministic vectors aimed at faults that random patterns seldom reach. With one stored seed used per boundary, a test of length T and run length B needs T / B − 1 table entries. For example, 3770 patterns in runs of 377 use nine stored seeds.

A launch pulse captures the run length, the number of stored seeds to use, the feedback tap mask and the initial seed. The block then emits one pattern per clock with a valid strobe and the index of the current run. When the last run ends it raises done and holds it until the next launch. The seed table is filled through a simple write port. Choosing good seeds and tap masks is left to the user.

Top module: `rsd_gen`

## Requirements
- R1: After reset, pattern_valid is 0, done is 0 and block_idx is 0.
- R2: A start pulse while idle or done makes the next cycle show pattern_valid = 1, block_idx = 0 and pattern equal to the captured init_seed.
- R3: Within a run, each pattern p is followed in the next cycle by {p[W-2:0], ^(p & taps)}, where taps bit i set means state bit i feeds the XOR.
- R4: After the last pattern of run k (when k is below the seed count), the next cycle shows block_idx = k+1 and the table entry at address k. No cycle is lost at the boundary.
- R5: A seed of all zeros, whether initial or stored, is replaced by the value 1 when it is loaded.
- R6: Exactly (M+1) × B valid patterns are emitted. The cycle after the last one shows pattern_valid = 0 and done = 1, and done stays high until the next start.
- R7: A start pulse while patterns are being emitted has no effect on the sequence.
- R8: A run length of 0 is treated as 1, and a seed count above the table depth is treated as the depth.
- R9: With a seed count of 0 the test is a single run from the initial seed.
- R10: Changes to block_size, seed_count and taps while a test is in progress do not alter that test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, captures the settings |
| init_seed | input | W | Seed of the first run |
| block_size | input | BS_W | Patterns per run (B) |
| seed_count | input | IDX_W | Number of stored seeds to use (M) |
| taps | input | W | Feedback tap mask |
| seed_wr_en | input | 1 | Seed table write enable |
| seed_wr_addr | input | AW | Seed table write address |
| seed_wr_data | input | W | Seed table write data |
| pattern | output | W | Current test pattern |
| pattern_valid | output | 1 | Pattern is part of the test |
| block_idx | output | IDX_W | Index of the current run |
| done | output | 1 | Test finished |

## Verification
Random tap masks, run lengths from 1 to 20 and seed counts from 0 to the table depth exercise both the shift step and the reload step. A wrong feedback bit shows up inside a run, and a wrong table address or an off-by-one run length shows up at a boundary. Directed runs use zero seeds, a run length of 0, an oversized seed count and a single run, which separate the substitution and clamping paths from the normal count. One run changes the launch inputs and pulses start mid-test, to show that the captured settings are the only ones in force.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;
endpackage

// File: rtl/rsd_seed_store.sv
module rsd_seed_store #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/rsd_seed_fix.sv
module rsd_seed_fix #(
    parameter int          W            = 16,
    parameter logic [W-1:0] DEFAULT_SEED = 1
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] clean
);
    // A zero state would never leave zero, so it is swapped for a live value.
    always_comb begin
        clean = (raw == '0) ? DEFAULT_SEED : raw;
    end
endmodule

// File: rtl/rsd_lfsr_step.sv
module rsd_lfsr_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] taps,
    output logic [W-1:0] nxt
);
    always_comb begin
        nxt = {cur[W-2:0], ^(cur & taps)};
    end
endmodule

// File: rtl/rsd_gen.sv
module rsd_gen
    import rsd_pkg::*;
#(
    parameter int           W            = 16,
    parameter int           DEPTH        = 8,
    parameter int           BS_W         = 12,
    parameter logic [W-1:0] DEFAULT_SEED = 1,
    localparam int          AW           = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int          IDX_W        = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W-1:0]     init_seed,
    input  logic [BS_W-1:0]  block_size,
    input  logic [IDX_W-1:0] seed_count,
    input  logic [W-1:0]     taps,
    input  logic             seed_wr_en,
    input  logic [AW-1:0]    seed_wr_addr,
    input  logic [W-1:0]     seed_wr_data,
    output logic [W-1:0]     pattern,
    output logic             pattern_valid,
    output logic [IDX_W-1:0] block_idx,
    output logic             done
);
    localparam logic [IDX_W-1:0] DEPTH_I = IDX_W'(DEPTH);

    typedef struct packed {
        phase_e           phase;
        logic [W-1:0]     pat;
        logic [BS_W-1:0]  pos;
        logic [BS_W-1:0]  bs;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] nseeds;
        logic [W-1:0]     taps;
    } state_t;

    state_t state_d, state_q;

    logic [W-1:0] init_clean;
    logic [W-1:0] mem_raw;
    logic [W-1:0] mem_clean;
    logic [W-1:0] shifted;

    rsd_seed_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (seed_wr_en),
        .wr_addr (seed_wr_addr),
        .wr_data (seed_wr_data),
        .rd_addr (state_q.idx[AW-1:0]),
        .rd_data (mem_raw)
    );

    rsd_seed_fix #(.W(W), .DEFAULT_SEED(DEFAULT_SEED)) u_fix_init (
        .raw   (init_seed),
        .clean (init_clean)
    );

    rsd_seed_fix #(.W(W), .DEFAULT_SEED(DEFAULT_SEED)) u_fix_mem (
        .raw   (mem_raw),
        .clean (mem_clean)
    );

    rsd_lfsr_step #(.W(W)) u_step (
        .cur  (state_q.pat),
        .taps (state_q.taps),
        .nxt  (shifted)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q.phase)
            PH_RUN: begin
                if (state_q.pos == state_q.bs - BS_W'(1)) begin
                    if (state_q.idx == state_q.nseeds) begin
                        state_d.phase = PH_DONE;
                    end else begin
                        // run k+1 takes table entry k
                        state_d.idx = state_q.idx + IDX_W'(1);
                        state_d.pat = mem_clean;
                        state_d.pos = '0;
                    end
                end else begin
                    state_d.pat = shifted;
                    state_d.pos = state_q.pos + BS_W'(1);
                end
            end
            default: begin
                if (start) begin
                    state_d.phase  = PH_RUN;
                    state_d.pat    = init_clean;
                    state_d.pos    = '0;
                    state_d.idx    = '0;
                    state_d.bs     = (block_size == '0) ? BS_W'(1) : block_size;
                    state_d.nseeds = (seed_count > DEPTH_I) ? DEPTH_I : seed_count;
                    state_d.taps   = taps;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign pattern       = state_q.pat;
    assign pattern_valid = (state_q.phase == PH_RUN);
    assign done          = (state_q.phase == PH_DONE);
    assign block_idx     = state_q.idx;
endmodule

// File: rtl/rsd_gen_chk.sv
module rsd_gen_chk #(
    parameter int W     = 16,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [W-1:0]     pattern,
    input logic             pattern_valid,
    input logic [IDX_W-1:0] block_idx,
    input logic             done,
    input logic [IDX_W-1:0] last_idx
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !pattern_valid && !done); // R1

    AST_LAUNCH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!pattern_valid && start) |=> (pattern_valid && block_idx == '0)); // R2

    AST_SHIFT_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (pattern_valid && $past(pattern_valid) && block_idx == $past(block_idx))
        |-> pattern[W-1:1] == $past(pattern[W-2:0])); // R3

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pattern_valid && $past(pattern_valid) && block_idx != $past(block_idx))
        |-> block_idx == $past(block_idx) + IDX_W'(1)); // R4

    AST_SEED_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pattern_valid && (!$past(pattern_valid) || block_idx != $past(block_idx)))
        |-> pattern != '0); // R5

    AST_VALID_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pattern_valid && done)); // R6

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pattern_valid |-> block_idx <= last_idx); // R6

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R6

    AST_RUN_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (pattern_valid && start) |=> (block_idx >= $past(block_idx))); // R7
endmodule

bind rsd_gen rsd_gen_chk #(.W(W), .IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .pattern       (pattern),
    .pattern_valid (pattern_valid),
    .block_idx     (block_idx),
    .done          (done),
    .last_idx      (state_q.nseeds)
);

// File: tb/tb_rsd_gen.sv
`timescale 1ns/1ps
module tb_rsd_gen;
    localparam int W     = 16;
    localparam int DEPTH = 8;
    localparam int BS_W  = 12;
    localparam int AW    = 3;
    localparam int IDX_W = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start;
    logic [W-1:0]     init_seed;
    logic [BS_W-1:0]  block_size;
    logic [IDX_W-1:0] seed_count;
    logic [W-1:0]     taps;
    logic             seed_wr_en;
    logic [AW-1:0]    seed_wr_addr;
    logic [W-1:0]     seed_wr_data;
    logic [W-1:0]     pattern;
    logic             pattern_valid;
    logic [IDX_W-1:0] block_idx;
    logic             done;

    int n_chk  = 0;
    int n_fail = 0;
    logic [W-1:0] seeds [DEPTH];

    always #10 clk = ~clk;

    rsd_gen dut (
        .clk(clk), .rst_n(rst_n), .start(start), .init_seed(init_seed),
        .block_size(block_size), .seed_count(seed_count), .taps(taps),
        .seed_wr_en(seed_wr_en), .seed_wr_addr(seed_wr_addr), .seed_wr_data(seed_wr_data),
        .pattern(pattern), .pattern_valid(pattern_valid), .block_idx(block_idx), .done(done)
    );

    function automatic logic [W-1:0] model_step(input logic [W-1:0] p, input logic [W-1:0] t);
        return {p[W-2:0], ^(p & t)};
    endfunction

    function automatic logic [W-1:0] model_fix(input logic [W-1:0] s);
        return (s == '0) ? W'(1) : s;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic write_seed(input int a, input logic [W-1:0] v);
        seed_wr_en   = 1'b1;
        seed_wr_addr = AW'(a);
        seed_wr_data = v;
        seeds[a]     = v;
        @(negedge clk);
        seed_wr_en   = 1'b0;
    endtask

    task automatic run_test(input logic [W-1:0] iseed, input int bs, input int m,
                            input logic [W-1:0] tp, input bit poke, input string extra);
        int bs_e;
        int m_e;
        logic [W-1:0] exp;
        string req;
        init_seed  = iseed;
        block_size = BS_W'(bs);
        seed_count = IDX_W'(m);
        taps       = tp;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        bs_e = (bs == 0) ? 1 : bs;
        m_e  = (m > DEPTH) ? DEPTH : m;
        exp  = model_fix(iseed);
        for (int b = 0; b <= m_e; b++) begin
            for (int p = 0; p < bs_e; p++) begin
                if (b == 0 && p == 0) req = {"R2", extra};
                else if (p == 0) req = {"R4", extra};
                else req = {"R3", extra};
                chk(req, "valid", 32'(pattern_valid), 32'd1);
                chk(req, "pattern", 32'(pattern), 32'(exp));
                chk(req, "block_idx", 32'(block_idx), 32'(b));
                if (poke && b == 0 && p == 0) begin
                    start      = 1'b1;
                    block_size = BS_W'(bs + 5);
                    seed_count = '0;
                    taps       = ~tp;
                end
                if (p < bs_e - 1) exp = model_step(exp, tp);
                else if (b < m_e) exp = model_fix(seeds[b]);
                @(negedge clk);
                start = 1'b0;
            end
        end
        chk({"R6", extra}, "done after last", 32'(done), 32'd1);
        chk({"R6", extra}, "valid after last", 32'(pattern_valid), 32'd0);
        @(negedge clk);
        @(negedge clk);
        chk("R6", "done held", 32'(done), 32'd1);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; start = 1'b0; init_seed = '0; block_size = '0; seed_count = '0;
        taps = '0; seed_wr_en = 1'b0; seed_wr_addr = '0; seed_wr_data = '0;
        repeat (3) @(negedge clk);
        chk("R1", "valid in reset", 32'(pattern_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "valid", 32'(pattern_valid), 32'd0);
        chk("R1", "done", 32'(done), 32'd0);
        chk("R1", "block_idx", 32'(block_idx), 32'd0);

        for (int i = 0; i < DEPTH; i++) write_seed(i, W'(16'h1000 + i * 16'h0111));

        // directed corners
        run_test(16'hACE1, 4, 3, 16'hB400, 1'b0, " base");
        run_test(16'h0000, 3, 0, 16'h8016, 1'b0, " R5 R9");
        write_seed(1, '0);
        run_test(16'h1234, 2, 3, 16'hD008, 1'b0, " R5");
        run_test(16'h5A5A, 0, 15, 16'h8421, 1'b0, " R8");
        run_test(16'h0F0F, 5, 2, 16'hB400, 1'b1, " R7 R10");
        run_test(16'h7777, 6, DEPTH, 16'h6000, 1'b0, " full");

        // constrained random runs
        for (int r = 0; r < 20; r++) begin
            for (int i = 0; i < DEPTH; i++) begin
                logic [W-1:0] v;
                v = W'($urandom);
                if ($urandom_range(0, 7) == 0) v = '0;
                write_seed(i, v);
            end
            run_test(W'($urandom), $urandom_range(1, 20), $urandom_range(0, DEPTH),
                     W'($urandom), ($urandom_range(0, 3) == 0), " rnd");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule